// File: doc/BRIEF.md
# Flit Request Decoder and Translator

This block sits at the input of a structure-memory unit. It takes 16-bit flits from a shared bus and assembles each request from two or three of them. It decodes the opcode in the leading flit. That opcode is variable in width: its top two bits decide whether two following bits widen the address or extend the opcode. Every request, whichever tier its opcode came from, is rewritten as one fixed internal command. The command carries a dense 4-bit operation, a 12-bit address, a 16-bit data word and a 16-bit opaque return template.

Finished commands wait in a small in-order FIFO and leave through a valid/ready stream, where an execution stage (not part of this block) consumes them. A request addressed to another memory unit is taken off the bus and thrown away. A stray flit that does not carry the request marker is also taken off the bus and thrown away.

Leading flit layout: bit 15 is the request marker, bits 14:13 the unit identifier, bits 12:10 the base opcode, bits 9:8 the extension bits and bits 7:0 the low address or payload.

Top module: `flitReqDecoder`

## Requirements
- R1: When base opcode bits 12:11 are not both 1, the internal op equals the 3-bit base (0 to 5), and the address is bits 9:0 of the leading flit, zero-extended to 12 bits.
- R2: When base opcode bits 12:11 are both 1, the op is 6 plus the 3-bit value {bit 10, bits 9:8}, giving 6 to 13. The address is bits 7:0, zero-extended to 12 bits. No op above 13 is ever produced.
- R3: For a two-flit request with internal op 1 (plain store) or 12 (immediate store), the second flit goes to the data field and the return field is zero. For every other two-flit op, the second flit goes to the return field and the data field is zero.
- R4: Internal ops 5 (extended) and 8 (compare-swap) span three flits. The second flit goes to the data field and the third to the return field.
- R5: A request whose identifier bits 14:13 differ from the configured identifier has all of its flits (two or three) accepted, and it yields no command. The flit after it is decoded as a new leading flit.
- R6: A leading flit with bit 15 clear is accepted and discarded on its own. It yields no command, and the next flit is decoded as a leading flit.
- R7: The FIFO holds up to 4 commands and delivers them in arrival order.
- R8: flitReady goes low only when the final flit of a matching request is offered while the FIFO holds 4 commands. It returns high once a command has been taken.
- R9: While cmdValid is high and cmdReady is low, every command output holds its value.
- R10: After reset, cmdValid is low, flitReady is high and the next flit is treated as a leading flit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| myId | input | 2 | Configured identifier of this memory unit |
| flitValid | input | 1 | Incoming flit is valid |
| flitData | input | 16 | Incoming flit |
| flitReady | output | 1 | Flit is accepted at this edge |
| cmdValid | output | 1 | Command at FIFO head is valid |
| cmdReady | input | 1 | Consumer takes the head command |
| cmdOp | output | 4 | Internal operation code |
| cmdAddr | output | 12 | Zero-extended cell address or payload |
| cmdData | output | 16 | Data word |
| cmdRet | output | 16 | Opaque return template |

## Verification
The bench sweeps all 32 combinations of base opcode and extension bits against several low-byte patterns. This exercises the tier boundary, where a decoder that used the wrong gate would leak extension bits into the restricted address or return a wrong dense op. Foreign-identifier requests of both lengths are followed by a matching request: a framing slip would misread that request's second flit as a header. A fifth request is offered against a full FIFO to show that the final flit stalls and that order survives. A design that overwrote a FIFO entry or lost the stalled flit would deliver a wrong or missing command.

// File: rtl/flitReqPkg.sv
package flitReqPkg;
  localparam int FLIT_W = 16;
  localparam int OP_W   = 4;
  localparam int ADDR_W = 12;
  localparam int ID_W   = 2;

  localparam logic [OP_W-1:0] OP_STORE = 4'd1;
  localparam logic [OP_W-1:0] OP_EXT   = 4'd5;
  localparam logic [OP_W-1:0] OP_TIER2 = 4'd6;
  localparam logic [OP_W-1:0] OP_CAS   = 4'd8;
  localparam logic [OP_W-1:0] OP_STIMM = 4'd12;

  typedef struct packed {
    logic [OP_W-1:0]   op;
    logic [ADDR_W-1:0] addr;
    logic [FLIT_W-1:0] data;
    logic [FLIT_W-1:0] ret;
  } cmdT;

  typedef struct packed {
    logic capHead;
    logic capSecond;
    logic push;
    logic pop;
  } strobeT;
endpackage

// File: rtl/flitReqCtrl.sv
module flitReqCtrl
  import flitReqPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   flitValid,
  input  logic   decIsReq,
  input  logic   decMatch,
  input  logic   decLong,
  input  logic   fifoFull,
  input  logic   cmdValid,
  input  logic   cmdReady,
  output logic   flitReady,
  output strobeT strobe
);
  typedef enum logic [1:0] {S_HEAD, S_SECOND, S_THIRD} stateT;

  stateT state;
  logic  keepQ;
  logic  longQ;
  logic  lastFlit;
  logic  accept;

  always_comb begin
    lastFlit  = (state == S_SECOND && !longQ) || (state == S_THIRD);
    flitReady = !(lastFlit && keepQ && fifoFull);
    accept    = flitValid && flitReady;
    strobe.capHead   = accept && (state == S_HEAD) && decIsReq;
    strobe.capSecond = accept && (state == S_SECOND);
    strobe.push      = accept && lastFlit && keepQ;
    strobe.pop       = cmdValid && cmdReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_HEAD;
      keepQ <= 1'b0;
      longQ <= 1'b0;
    end else if (accept) begin
      case (state)
        S_HEAD: begin
          if (decIsReq) begin
            state <= S_SECOND;
            keepQ <= decMatch;
            longQ <= decLong;
          end
        end
        S_SECOND: state <= longQ ? S_THIRD : S_HEAD;
        default:  state <= S_HEAD;
      endcase
    end
  end
endmodule

// File: rtl/flitReqPath.sv
module flitReqPath
  import flitReqPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FLIT_W-1:0] flitData,
  input  logic [ID_W-1:0]   myId,
  input  strobeT            strobe,
  output logic              decIsReq,
  output logic              decMatch,
  output logic              decLong,
  output logic              fifoFull,
  output logic              cmdValid,
  output cmdT               cmdHead
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

  logic [2:0]        baseOp;
  logic [1:0]        extBits;
  logic              tier2;
  logic [OP_W-1:0]   decOp;
  logic [ADDR_W-1:0] decAddr;

  logic [OP_W-1:0]   opQ;
  logic [ADDR_W-1:0] addrQ;
  logic [FLIT_W-1:0] secondQ;
  cmdT               newCmd;

  cmdT               slots [DEPTH];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;
  logic [CNT_W-1:0]  count;

  always_comb begin
    baseOp   = flitData[12:10];
    extBits  = flitData[9:8];
    tier2    = baseOp[2] & baseOp[1];
    decOp    = tier2 ? (OP_TIER2 + {1'b0, baseOp[0], extBits}) : {1'b0, baseOp};
    decAddr  = tier2 ? {4'b0, flitData[7:0]} : {2'b0, extBits, flitData[7:0]};
    decIsReq = flitData[15];
    decMatch = (flitData[14:13] == myId);
    decLong  = (decOp == OP_EXT) || (decOp == OP_CAS);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opQ     <= '0;
      addrQ   <= '0;
      secondQ <= '0;
    end else begin
      if (strobe.capHead) begin
        opQ   <= decOp;
        addrQ <= decAddr;
      end
      if (strobe.capSecond) secondQ <= flitData;
    end
  end

  always_comb begin
    newCmd.op   = opQ;
    newCmd.addr = addrQ;
    if (opQ == OP_EXT || opQ == OP_CAS) begin
      newCmd.data = secondQ;
      newCmd.ret  = flitData;
    end else if (opQ == OP_STORE || opQ == OP_STIMM) begin
      newCmd.data = flitData;
      newCmd.ret  = '0;
    end else begin
      newCmd.data = '0;
      newCmd.ret  = flitData;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.push) slots[wrPtr] <= newCmd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.push) wrPtr <= (wrPtr == LAST_SLOT) ? '0 : wrPtr + 1'b1;
      if (strobe.pop)  rdPtr <= (rdPtr == LAST_SLOT) ? '0 : rdPtr + 1'b1;
      case ({strobe.push, strobe.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign fifoFull = (count == FULL_CNT);
  assign cmdValid = (count != '0);
  assign cmdHead  = slots[rdPtr];
endmodule

// File: rtl/flitReqDecoder.sv
module flitReqDecoder
  import flitReqPkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  myId,
  input  logic        flitValid,
  input  logic [15:0] flitData,
  output logic        flitReady,
  output logic        cmdValid,
  input  logic        cmdReady,
  output logic [3:0]  cmdOp,
  output logic [11:0] cmdAddr,
  output logic [15:0] cmdData,
  output logic [15:0] cmdRet
);
  strobeT strobe;
  cmdT    cmdHead;
  logic   decIsReq;
  logic   decMatch;
  logic   decLong;
  logic   fifoFull;

  flitReqCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .flitValid(flitValid),
    .decIsReq(decIsReq), .decMatch(decMatch), .decLong(decLong),
    .fifoFull(fifoFull), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .flitReady(flitReady), .strobe(strobe)
  );

  flitReqPath #(.DEPTH(DEPTH)) u_path (
    .clk(clk), .rstN(rstN), .flitData(flitData), .myId(myId),
    .strobe(strobe), .decIsReq(decIsReq), .decMatch(decMatch),
    .decLong(decLong), .fifoFull(fifoFull), .cmdValid(cmdValid),
    .cmdHead(cmdHead)
  );

  assign cmdOp   = cmdHead.op;
  assign cmdAddr = cmdHead.addr;
  assign cmdData = cmdHead.data;
  assign cmdRet  = cmdHead.ret;
endmodule

// File: rtl/flitReqChecker.sv
module flitReqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        flitReady,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [3:0]  cmdOp,
  input logic [11:0] cmdAddr,
  input logic [15:0] cmdData,
  input logic [15:0] cmdRet
);
  // R8: a stall is only possible with commands waiting
  a_r8_stall_needs_backlog: assert property (@(posedge clk) disable iff (!rstN)
    !flitReady |-> cmdValid);

  // R9: head command holds while not taken
  a_r9_hold_head: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable({cmdOp, cmdAddr, cmdData, cmdRet}));

  // R1: addresses never exceed 10 bits
  a_r1_addr_span: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdAddr[11:10] == 2'b00);

  // R2: restricted tier carries 8-bit addresses only
  a_r2_tier2_addr: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdOp >= 4'd6 |-> cmdAddr[11:8] == 4'h0);

  // R2: dense op space ends at 13
  a_r2_op_limit: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> cmdOp <= 4'd13);

  // R3: store ops carry no return template
  a_r3_store_noret: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && (cmdOp == 4'd1 || cmdOp == 4'd12) |-> cmdRet == 16'h0);
endmodule

bind flitReqDecoder flitReqChecker u_chk (
  .clk(clk), .rstN(rstN), .flitReady(flitReady), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
  .cmdData(cmdData), .cmdRet(cmdRet)
);

// File: tb/flitReqDecoder_tb.sv
`timescale 1ns/1ps
module flitReqDecoder_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  myId = 2'd2;
  logic        flitValid = 1'b0;
  logic [15:0] flitData = '0;
  logic        flitReady;
  logic        cmdValid;
  logic        cmdReady = 1'b0;
  logic [3:0]  cmdOp;
  logic [11:0] cmdAddr;
  logic [15:0] cmdData;
  logic [15:0] cmdRet;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flitReqDecoder u_dut (
    .clk(clk), .rstN(rstN), .myId(myId), .flitValid(flitValid),
    .flitData(flitData), .flitReady(flitReady), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdAddr(cmdAddr),
    .cmdData(cmdData), .cmdRet(cmdRet)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendFlit(input logic [15:0] d);
    @(negedge clk);
    flitValid = 1'b1;
    flitData  = d;
    #1;
    while (!flitReady) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    flitValid = 1'b0;
  endtask

  function automatic logic [15:0] head(input logic [1:0] id, input int code, input logic [7:0] low);
    return {1'b1, id, 3'(code >> 2), 2'(code & 3), low};
  endfunction

  function automatic logic [3:0] expOp(input int code);
    int base = code >> 2;
    if (base < 6) return 4'(base);
    return 4'(6 + (((base & 1) << 2) | (code & 3)));
  endfunction

  function automatic logic [11:0] expAddr(input int code, input logic [7:0] low);
    if ((code >> 2) < 6) return {2'b0, 2'(code & 3), low};
    return {4'b0, low};
  endfunction

  function automatic bit isLong(input logic [3:0] op);
    return op == 4'd5 || op == 4'd8;
  endfunction

  // send a full request with given id/code; second and third flit values
  task automatic sendReq(input logic [1:0] id, input int code, input logic [7:0] low,
                         input logic [15:0] sec, input logic [15:0] thd);
    sendFlit(head(id, code, low));
    sendFlit(sec);
    if (isLong(expOp(code))) sendFlit(thd);
  endtask

  task automatic expectHead(input string tag, input int code, input logic [7:0] low,
                            input logic [15:0] sec, input logic [15:0] thd);
    logic [3:0] op = expOp(code);
    logic [15:0] eData;
    logic [15:0] eRet;
    if (isLong(op)) begin
      eData = sec; eRet = thd;
    end else if (op == 4'd1 || op == 4'd12) begin
      eData = sec; eRet = 16'h0;
    end else begin
      eData = 16'h0; eRet = sec;
    end
    check({tag, " valid"}, 32'(cmdValid), 32'd1);
    check({tag, " op"},    32'(cmdOp),    32'(op));
    check({tag, " addr"},  32'(cmdAddr),  32'(expAddr(code, low)));
    check({tag, " data"},  32'(cmdData),  32'(eData));
    check({tag, " ret"},   32'(cmdRet),   32'(eRet));
  endtask

  task automatic popCmd();
    @(negedge clk);
    cmdReady = 1'b1;
    @(posedge clk);
    #1;
    cmdReady = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finishRun();
  end

  initial begin
    logic [7:0] lows [3];
    lows[0] = 8'h00; lows[1] = 8'hA5; lows[2] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R10 reset state
    check("R10 cmdValid", 32'(cmdValid), 32'd0);
    check("R10 flitReady", 32'(flitReady), 32'd1);

    // R1 R2 R3 R4 sweep over all opcode/extension combinations
    for (int code = 0; code < 32; code++) begin
      for (int k = 0; k < 3; k++) begin
        logic [15:0] sec = 16'h5A00 ^ 16'(code * 37 + k);
        logic [15:0] thd = 16'hC300 + 16'(code * 5 + k);
        sendReq(myId, code, lows[k], sec, thd);
        @(negedge clk);
        expectHead((code >> 2) < 6 ? "R1" : "R2", code, lows[k], sec, thd);
        if (expOp(code) == 4'd1 || expOp(code) == 4'd12) check("R3 store", 32'(cmdRet), 32'd0);
        if (isLong(expOp(code))) check("R4 third flit", 32'(cmdRet), 32'(thd));
        popCmd();
        @(negedge clk);
        check("R7 drained", 32'(cmdValid), 32'd0);
      end
    end

    // R5 foreign requests of both lengths, then a matching one
    sendReq(2'd1, 0, 8'h11, 16'h1111, 16'h0);
    sendReq(2'd3, 21, 8'h22, 16'h2222, 16'h3333);
    sendReq(2'd0, 8, 8'h33, 16'h4444, 16'h5555);
    @(negedge clk);
    check("R5 no command", 32'(cmdValid), 32'd0);
    sendReq(myId, 4, 8'h44, 16'h6666, 16'h0);
    @(negedge clk);
    expectHead("R5 framing", 4, 8'h44, 16'h6666, 16'h0);
    popCmd();

    // R6 stray non-request flit
    sendFlit(16'h0123);
    @(negedge clk);
    check("R6 no command", 32'(cmdValid), 32'd0);
    sendReq(myId, 7, 8'h9C, 16'h7777, 16'h0);
    @(negedge clk);
    expectHead("R6 framing", 7, 8'h9C, 16'h7777, 16'h0);
    popCmd();

    // R7 R8 R9 fill four, stall the fifth
    for (int i = 0; i < 4; i++) sendReq(myId, 4 + i, 8'(i), 16'h0A00 + 16'(i), 16'h0);
    sendFlit(head(myId, 4 + 4, 8'h04));
    @(negedge clk);
    flitValid = 1'b1;
    flitData  = 16'h0A04;
    #1;
    check("R8 stall on full", 32'(flitReady), 32'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R8 stall held", 32'(flitReady), 32'd0);
    expectHead("R9 head held", 4, 8'h00, 16'h0A00, 16'h0);
    cmdReady = 1'b1;
    @(posedge clk);
    #1;
    cmdReady = 1'b0;
    check("R8 ready after pop", 32'(flitReady), 32'd1);
    @(posedge clk);
    #1;
    flitValid = 1'b0;
    for (int i = 1; i < 5; i++) begin
      @(negedge clk);
      expectHead("R7 order", 4 + i, 8'(i), 16'h0A00 + 16'(i), 16'h0);
      popCmd();
    end
    @(negedge clk);
    check("R7 empty after five", 32'(cmdValid), 32'd0);
    finishRun();
  end
endmodule